// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block steps a DMA controller through the bus states of every transfer in a service. The controller has fewer address pins than address bits, so the upper address byte goes out on the data lines and an outside latch holds it. The sequencer decides when that byte must be refreshed, and it drives the latch strobe, the address enable, the read and write strobes and the end-of-process flag. A transfer runs through an optional upper-byte state S1, an address state S2, an optional read-stretch state S3 and a read/write state S4.

The address and word-count registers are outside the block. They present the address of the transfer being run and a terminal-count flag for it, and they step on the clock edge that ends S4. The sequencer looks at the low byte and the count direction in S4. It enters S1 again only when the next step carries or borrows out of bit 7. Compressed timing drops S3 and moves the end-of-process flag into S2. Compressed timing is refused when memory-to-memory is selected. There is no data stream at this edge, so there is no valid/ready handshake: every pin is a plain level sampled on the rising clock.

Top module: `dma_cycle_seq`

## Requirements
- R1: While reset is low the state output reads 0 (idle) and AEN, ADSTB, both strobes, EOP, the low address and the data lines are all 0. State codes: 0 idle, 1 S1, 2 S2, 3 S3, 4 S4.
- R2: In idle with grant high, the next state is S1, so the first transfer of every service includes S1.
- R3: ADSTB is high exactly in S1, which lasts one cycle and is followed by S2. The data lines carry addr[15:8] in S1 and 0 in every other state.
- R4: With normal timing, S2 is followed by S3 and S3 by S4. The read strobe is high in S3 and S4, and the write strobe is high in S4 only.
- R5: With compressed timing (cmp_en=1, mem2mem=0), S2 is followed directly by S4, and both strobes are high in S4 only.
- R6: When mem2mem=1, cmp_en has no effect and the transfer uses normal timing.
- R7: When a service continues past S4, the next state is S1 if addr_down=0 and addr[7:0]=FFh, or if addr_down=1 and addr[7:0]=00h. Otherwise the next state is S2.
- R8: When tc=1, EOP is high in S4 with normal timing and in S2 with compressed timing. EOP is low in every other cycle.
- R9: After S4 the sequencer returns to idle if tc=1, or if the mode is single (01), or if the mode is demand (00) and grant is low. Block mode (10, and 11 which acts the same) ignores grant until tc.
- R10: AEN is high in every state except idle. The low address lines carry addr[7:0] while AEN is high and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| grant | input | 1 | Bus granted to the DMA controller |
| mode | input | 2 | 00 demand, 01 single, 10/11 block |
| cmp_en | input | 1 | Compressed timing requested |
| mem2mem | input | 1 | Memory-to-memory transfer selected |
| addr_down | input | 1 | Address counts down when 1 |
| addr | input | 16 | Current address of the transfer |
| tc | input | 1 | This transfer is the terminal one |
| state | output | 3 | Bus state code |
| addr_lo | output | 8 | Low address byte |
| db_hi | output | 8 | Upper address byte on the data lines |
| adstb | output | 1 | Upper-byte latch strobe |
| aen | output | 1 | Address enable |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| eop | output | 1 | End of process |

## Verification
The assertions assume that mode, cmp_en, mem2mem and addr_down stay constant from grant until the return to idle. They also assume that addr and tc change only on the edge that leaves S4, as the outside registers would make them. The stimulus loads a fresh configuration, start address and word count only while the reference model is idle and grant is low. The bench keeps its own address and count registers, which step exactly when the modelled state leaves S4. Start addresses are skewed toward low bytes near 00h and FFh so that carries and borrows are hit often.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S1   = 3'd1,
    ST_S2   = 3'd2,
    ST_S3   = 3'd3,
    ST_S4   = 3'd4
  } dcs_state_e;

  typedef enum logic [1:0] {
    MODE_DEMAND = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_BLOCK  = 2'b10,
    MODE_BLOCK2 = 2'b11
  } dcs_mode_e;

endpackage

// File: rtl/dcs_hop.sv
// Flags that the next address step crosses into a new upper byte.
module dcs_hop #(
  parameter int LO_W = 8
) (
  input  logic [LO_W-1:0] lo,
  input  logic            down,
  output logic            hop
);
  always_comb begin
    if (down) hop = (lo == {LO_W{1'b0}});
    else      hop = (lo == {LO_W{1'b1}});
  end
endmodule

// File: rtl/dcs_fsm.sv
// State register and next-state choice for one transfer service.
module dcs_fsm
  import dcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grant,
  input  logic [1:0] mode,
  input  logic       fast,
  input  logic       tc,
  input  logic       hop,
  output dcs_state_e state
);
  dcs_state_e nxt;
  logic       finish;

  always_comb begin
    finish = tc
           | (mode == MODE_SINGLE)
           | ((mode == MODE_DEMAND) & ~grant);
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: nxt = grant ? ST_S1 : ST_IDLE;
      ST_S1:   nxt = ST_S2;
      ST_S2:   nxt = fast ? ST_S4 : ST_S3;
      ST_S3:   nxt = ST_S4;
      ST_S4: begin
        if (finish)   nxt = ST_IDLE;
        else if (hop) nxt = ST_S1;
        else          nxt = ST_S2;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/dcs_strobe.sv
// Decodes the bus state into pin levels.
module dcs_strobe
  import dcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LO_W   = 8
) (
  input  dcs_state_e               state,
  input  logic                     tc,
  input  logic                     fast,
  input  logic [ADDR_W-1:0]        addr,
  output logic [LO_W-1:0]          addr_lo,
  output logic [ADDR_W-LO_W-1:0]   db_hi,
  output logic                     adstb,
  output logic                     aen,
  output logic                     rd_stb,
  output logic                     wr_stb,
  output logic                     eop
);
  localparam int HI_W = ADDR_W - LO_W;

  logic in_s1, in_s2, in_s3, in_s4;

  always_comb begin
    in_s1   = (state == ST_S1);
    in_s2   = (state == ST_S2);
    in_s3   = (state == ST_S3);
    in_s4   = (state == ST_S4);
    aen     = (state != ST_IDLE);
    addr_lo = aen ? addr[LO_W-1:0] : {LO_W{1'b0}};
    db_hi   = in_s1 ? addr[ADDR_W-1:LO_W] : {HI_W{1'b0}};
    adstb   = in_s1;
    rd_stb  = in_s3 | in_s4;
    wr_stb  = in_s4;
    eop     = tc & (fast ? in_s2 : in_s4);
  end
endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
  import dcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LO_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     grant,
  input  logic [1:0]               mode,
  input  logic                     cmp_en,
  input  logic                     mem2mem,
  input  logic                     addr_down,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     tc,
  output logic [2:0]               state,
  output logic [LO_W-1:0]          addr_lo,
  output logic [ADDR_W-LO_W-1:0]   db_hi,
  output logic                     adstb,
  output logic                     aen,
  output logic                     rd_stb,
  output logic                     wr_stb,
  output logic                     eop
);
  dcs_state_e st;
  logic       fast;
  logic       hop;

  // Compressed timing is refused for memory-to-memory work.
  assign fast  = cmp_en & ~mem2mem;
  assign state = st;

  dcs_hop #(.LO_W(LO_W)) u_hop (
    .lo   (addr[LO_W-1:0]),
    .down (addr_down),
    .hop  (hop)
  );

  dcs_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .grant (grant),
    .mode  (mode),
    .fast  (fast),
    .tc    (tc),
    .hop   (hop),
    .state (st)
  );

  dcs_strobe #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_strobe (
    .state   (st),
    .tc      (tc),
    .fast    (fast),
    .addr    (addr),
    .addr_lo (addr_lo),
    .db_hi   (db_hi),
    .adstb   (adstb),
    .aen     (aen),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .eop     (eop)
  );
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int LO_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            grant,
  input logic [1:0]      mode,
  input logic            cmp_en,
  input logic            mem2mem,
  input logic            addr_down,
  input logic [LO_W-1:0] lo,
  input logic            tc,
  input logic [2:0]      state,
  input logic            adstb,
  input logic            aen,
  input logic            eop
);
  assert_idle_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && grant) |=> (state == 3'd1));

  assert_adstb_then_s2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adstb |=> (state == 3'd2));

  assert_normal_s3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 && !(cmp_en && !mem2mem)) |=> (state == 3'd3));

  assert_fast_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 && cmp_en && !mem2mem) |=> (state == 3'd4));

  assert_m2m_no_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 && mem2mem) |=> (state == 3'd3));

  assert_no_hop_s2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && !tc && mode[1] && !addr_down && lo != {LO_W{1'b1}})
      |=> (state == 3'd2));

  assert_eop_place_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eop) |-> (state == 3'd2 || state == 3'd4));

  assert_tc_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && tc) |=> (state == 3'd0));

  assert_aen_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 3'd0) |-> aen);
endmodule

bind dma_cycle_seq dcs_checker #(.LO_W(LO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .grant     (grant),
  .mode      (mode),
  .cmp_en    (cmp_en),
  .mem2mem   (mem2mem),
  .addr_down (addr_down),
  .lo        (addr[LO_W-1:0]),
  .tc        (tc),
  .state     (state),
  .adstb     (adstb),
  .aen       (aen),
  .eop       (eop)
);

// File: tb/dma_cycle_seq_test.sv
`timescale 1ns/1ps
module dma_cycle_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        grant = 1'b0;
  logic [1:0]  mode = 2'b10;
  logic        cmp_en = 1'b0;
  logic        mem2mem = 1'b0;
  logic        addr_down = 1'b0;
  logic [15:0] m_addr = 16'h0;
  logic [15:0] m_cnt = 16'h1;
  logic [2:0]  m_st = 3'd0;
  logic        tc;

  logic [2:0]  state;
  logic [7:0]  addr_lo, db_hi;
  logic        adstb, aen, rd_stb, wr_stb, eop;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  assign tc = (m_cnt == 16'h0);

  always #4 clk = ~clk;

  dma_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .mode(mode), .cmp_en(cmp_en),
    .mem2mem(mem2mem), .addr_down(addr_down), .addr(m_addr), .tc(tc),
    .state(state), .addr_lo(addr_lo), .db_hi(db_hi), .adstb(adstb),
    .aen(aen), .rd_stb(rd_stb), .wr_stb(wr_stb), .eop(eop)
  );

  function automatic bit fast_f();
    return cmp_en && !mem2mem;
  endfunction

  // Next state from the requirements (R2, R4, R5, R7, R9).
  function automatic logic [2:0] next_f(logic [2:0] s);
    bit hop, fin;
    hop = addr_down ? (m_addr[7:0] == 8'h00) : (m_addr[7:0] == 8'hFF);
    fin = tc || mode == 2'b01 || (mode == 2'b00 && !grant);
    case (s)
      3'd0: return grant ? 3'd1 : 3'd0;
      3'd1: return 3'd2;
      3'd2: return fast_f() ? 3'd4 : 3'd3;
      3'd3: return 3'd4;
      3'd4: return fin ? 3'd0 : (hop ? 3'd1 : 3'd2);
      default: return 3'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_st <= 3'd0;
    else begin
      m_st <= next_f(m_st);
      if (m_st == 3'd4) begin
        m_addr <= addr_down ? m_addr - 16'd1 : m_addr + 16'd1;
        m_cnt  <= m_cnt - 16'd1;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string ts;
    bit    busy;
    busy = (m_st != 3'd0);
    if (m_st == 3'd0)      ts = "R9 state";
    else if (m_st == 3'd1) ts = "R7 state";
    else if (m_st == 3'd3) ts = "R4 state";
    else if (m_st == 3'd4) ts = fast_f() ? "R5 state" : (mem2mem ? "R6 state" : "R4 state");
    else                   ts = "R3 state";
    check(ts, state, m_st);
    check("R10 aen", aen, busy);
    check("R10 addr_lo", addr_lo, busy ? m_addr[7:0] : 8'h00);
    check("R3 adstb", adstb, m_st == 3'd1);
    check("R3 db_hi", db_hi, (m_st == 3'd1) ? m_addr[15:8] : 8'h00);
    check(fast_f() ? "R5 rd" : "R4 rd", rd_stb, m_st == 3'd3 || m_st == 3'd4);
    check(mem2mem ? "R6 wr" : "R4 wr", wr_stb, m_st == 3'd4);
    check("R8 eop", eop, tc && (fast_f() ? m_st == 3'd2 : m_st == 3'd4));
  endtask

  task automatic run_svc(logic [1:0] md, bit c, bit mm, bit dn,
                         logic [15:0] a, logic [15:0] cnt, bit may_drop);
    int n;
    mode = md; cmp_en = c; mem2mem = mm; addr_down = dn;
    m_addr = a; m_cnt = cnt; grant = 1'b1;
    n = 0;
    forever begin
      @(negedge clk);
      check_all();
      n++;
      if (m_st == 3'd0 || n > 400) break;
      if (may_drop && md == 2'b00 && ($urandom % 5) == 0) grant = 1'b0;
    end
    grant = 1'b0;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 state", state, 3'd0);
    check("R1 aen", aen, 1'b0);
    check("R1 strobes", {adstb, rd_stb, wr_stb, eop}, 4'h0);
    check("R1 buses", {addr_lo, db_hi}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R7 carry upward, normal timing, block
    run_svc(2'b10, 1'b0, 1'b0, 1'b0, 16'h12FE, 16'd3, 1'b0);
    // R7 borrow downward
    run_svc(2'b10, 1'b0, 1'b0, 1'b1, 16'h3401, 16'd3, 1'b0);
    // R5 compressed across a carry
    run_svc(2'b11, 1'b1, 1'b0, 1'b0, 16'h00FF, 16'd2, 1'b0);
    // R6 compressed request refused for memory-to-memory
    run_svc(2'b10, 1'b1, 1'b1, 1'b0, 16'h4480, 16'd2, 1'b0);
    // R9 single mode ends after one transfer
    run_svc(2'b01, 1'b0, 1'b0, 1'b0, 16'h5555, 16'd4, 1'b0);
    // R8 terminal on the only transfer
    run_svc(2'b10, 1'b1, 1'b0, 1'b1, 16'h7700, 16'd0, 1'b0);
    // R9 demand ended by grant loss
    run_svc(2'b00, 1'b0, 1'b0, 1'b0, 16'h0100, 16'd20, 1'b1);

    for (int i = 0; i < 300; i++) begin
      a = 16'($urandom);
      if ($urandom % 2 == 0) a[7:0] = 8'($urandom % 3) + (($urandom % 2 == 0) ? 8'hFD : 8'h00);
      run_svc(2'($urandom), 1'($urandom), ($urandom % 4) == 0, 1'($urandom),
              a, 16'($urandom % 6), 1'b1);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule